// File: doc/BRIEF.md
# Shared-Slot Instruction Dispatch Arbiter

This block holds a small pool of pending micro-ops and, every clock, picks up to five of them for five fixed dispatch slots. Each pool entry records a functional-unit class, three source-operand ready flags and an age that grows while the entry waits. A slot serves only its own set of classes. Two slots serve plain integer work. One slot is shared by multiply and divide. One serves loads and stores, and one serves branches and floating-point work. Multiply and divide share a slot, so at most one of them leaves per cycle. When both are ready, the divide goes first because it occupies its unit far longer.

Entries come in through a single write port that names the target entry. Operand flags are raised through a separate set port. Each entry is a three-state machine. FREE holds nothing. WAIT holds a micro-op with at least one operand missing. READY holds a micro-op whose three operands are all present. The transitions are: FREE→WAIT on a write with missing operands, FREE→READY on a write with all three flags set, WAIT→READY when a set completes the flags, and READY→FREE one clock after the entry is granted. Grants are combinational from the registered entry state.

Top module: `shared_slot_dispatch`

## Requirements
- R1: While reset is high, and in the first cycle after it, every entry is FREE and no slot reports a grant.
- R2: A write (`enq_valid`) to a FREE entry stores its class and operand flags, with age 0. A write to an entry that is not FREE is ignored, and the entry keeps its old class and flags.
- R3: Only an entry with all three operand flags set can be granted. A set (`set_valid`) ORs `set_mask` into the flags of a WAIT entry and has no effect on entries in other states.
- R4: Class codes are ALU=0, MUL=1, DIV=2, LOAD=3, STORE=4, BRANCH=5, FPU=6 and spare=7. Slots 0 and 1 take ALU, slot 2 takes MUL/DIV, slot 3 takes LOAD/STORE and slot 4 takes BRANCH/FPU.
- R5: Within a slot, the ready entry with the largest age wins. Age rises by one per cycle while the entry is occupied and saturates at its maximum. On equal age, the lower index wins.
- R6: Slot 2 grants a ready DIV whenever one exists, even if a ready MUL is older. It grants a MUL only when no DIV is ready, and never grants two entries.
- R7: Slot 0 grants the oldest ready ALU entry. Slot 1 grants the oldest ready ALU entry other than that one.
- R8: No entry is granted to two slots in one cycle. A granted entry is FREE in the next cycle and can be written again then.
- R9: An entry of class 7 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Write a micro-op into the pool |
| enq_idx | input | IW | Target entry of the write |
| enq_class | input | 3 | Functional-unit class code |
| enq_ops | input | 3 | Operand-ready flags of the new micro-op |
| set_valid | input | 1 | Raise operand flags of one entry |
| set_idx | input | IW | Entry whose flags are raised |
| set_mask | input | 3 | Flags to OR in |
| slot_vld | output | 5 | Per slot: a grant is made this cycle |
| slot_idx | output | 5×IW | Per slot: index of the granted entry |
| slot_grant | output | 5×DEPTH | Per slot: one-hot grant vector over entries |

## Verification
The assertions assume that entry indices on both write ports lie inside the pool. They also assume that reset is applied at start-up, so that every entry begins FREE. The bench draws indices only from 0 to DEPTH-1, so the first assumption holds. Its writes deliberately hit occupied entries and its sets hit FREE and READY entries, so that the ignore rules are exercised. Class 7 appears only in a directed case, followed by a second reset that clears the stuck entry before the random phase.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int NSLOT = 5;
    localparam int NOPS  = 3;

    typedef enum logic [2:0] {
        CL_ALU = 3'd0,
        CL_MUL = 3'd1,
        CL_DIV = 3'd2,
        CL_LD  = 3'd3,
        CL_ST  = 3'd4,
        CL_BR  = 3'd5,
        CL_FPU = 3'd6,
        CL_RSV = 3'd7
    } fu_class_e;

    typedef enum logic [1:0] {
        ES_FREE  = 2'd0,
        ES_WAIT  = 2'd1,
        ES_READY = 2'd2
    } ent_state_e;
endpackage

// File: rtl/dq_entry.sv
module dq_entry
    import dq_pkg::*;
#(
    parameter int AGE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enq,
    input  logic [2:0]           enq_class,
    input  logic [NOPS-1:0]      enq_ops,
    input  logic                 set,
    input  logic [NOPS-1:0]      set_mask,
    input  logic                 grant,
    output logic                 rdy,
    output logic                 free,
    output logic [2:0]           cls,
    output logic [AGE_W-1:0]     age
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    ent_state_e            st_q, st_d;
    logic [2:0]            cls_q, cls_d;
    logic [NOPS-1:0]       ops_q, ops_d;
    logic [AGE_W-1:0]      age_q, age_d;
    logic [AGE_W-1:0]      age_inc;

    assign age_inc = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ES_FREE;
            cls_q <= '0;
            ops_q <= '0;
            age_q <= '0;
        end else begin
            st_q  <= st_d;
            cls_q <= cls_d;
            ops_q <= ops_d;
            age_q <= age_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cls_d = cls_q;
        ops_d = ops_q;
        age_d = age_q;
        unique case (st_q)
            ES_FREE: begin
                if (enq) begin
                    cls_d = enq_class;
                    ops_d = enq_ops;
                    age_d = '0;
                    st_d  = (&enq_ops) ? ES_READY : ES_WAIT;
                end
            end
            ES_WAIT: begin
                age_d = age_inc;
                if (set) begin
                    ops_d = ops_q | set_mask;
                end
                if (&ops_d) begin
                    st_d = ES_READY;
                end
            end
            ES_READY: begin
                if (grant) begin
                    st_d = ES_FREE;
                end else begin
                    age_d = age_inc;
                end
            end
            default: st_d = ES_FREE;
        endcase
    end

    always_comb begin
        rdy  = (st_q == ES_READY);
        free = (st_q == ES_FREE);
        cls  = cls_q;
        age  = age_q;
    end
endmodule

// File: rtl/dq_pick.sv
module dq_pick #(
    parameter int DEPTH = 16,
    parameter int AGE_W = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             req,
    input  logic [DEPTH-1:0][AGE_W-1:0]  age,
    output logic                         found,
    output logic [IW-1:0]                idx
);
    logic [AGE_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i] && (!found || age[i] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = age[i];
            end
        end
    end
endmodule

// File: rtl/shared_slot_dispatch.sv
module shared_slot_dispatch
    import dq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AGE_W = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          enq_valid,
    input  logic [IW-1:0]                 enq_idx,
    input  logic [2:0]                    enq_class,
    input  logic [2:0]                    enq_ops,
    input  logic                          set_valid,
    input  logic [IW-1:0]                 set_idx,
    input  logic [2:0]                    set_mask,
    output logic [4:0]                    slot_vld,
    output logic [4:0][IW-1:0]            slot_idx,
    output logic [4:0][DEPTH-1:0]         slot_grant
);
    logic [DEPTH-1:0]             ent_rdy;
    logic [DEPTH-1:0]             ent_free;
    logic [DEPTH-1:0][2:0]        ent_cls;
    logic [DEPTH-1:0][AGE_W-1:0]  ent_age;
    logic [DEPTH-1:0]             ent_grant;

    logic [DEPTH-1:0] m_alu, m_alu2, m_mul, m_div, m_mem, m_brf;
    logic             f_alu0, f_alu1, f_mul, f_div, f_mem, f_brf;
    logic [IW-1:0]    i_alu0, i_alu1, i_mul, i_div, i_mem, i_brf;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        dq_entry #(.AGE_W(AGE_W)) u_ent (
            .clk       (clk),
            .rst       (rst),
            .enq       (enq_valid && enq_idx == IW'(g)),
            .enq_class (enq_class),
            .enq_ops   (enq_ops),
            .set       (set_valid && set_idx == IW'(g)),
            .set_mask  (set_mask),
            .grant     (ent_grant[g]),
            .rdy       (ent_rdy[g]),
            .free      (ent_free[g]),
            .cls       (ent_cls[g]),
            .age       (ent_age[g])
        );
        assign m_alu[g] = ent_rdy[g] && ent_cls[g] == CL_ALU;
        assign m_mul[g] = ent_rdy[g] && ent_cls[g] == CL_MUL;
        assign m_div[g] = ent_rdy[g] && ent_cls[g] == CL_DIV;
        assign m_mem[g] = ent_rdy[g] && (ent_cls[g] == CL_LD || ent_cls[g] == CL_ST);
        assign m_brf[g] = ent_rdy[g] && (ent_cls[g] == CL_BR || ent_cls[g] == CL_FPU);
    end

    dq_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u_p_alu0 (
        .req(m_alu), .age(ent_age), .found(f_alu0), .idx(i_alu0));

    always_comb begin
        m_alu2 = m_alu;
        if (f_alu0) m_alu2[i_alu0] = 1'b0;
    end

    dq_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u_p_alu1 (
        .req(m_alu2), .age(ent_age), .found(f_alu1), .idx(i_alu1));
    dq_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u_p_div (
        .req(m_div), .age(ent_age), .found(f_div), .idx(i_div));
    dq_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u_p_mul (
        .req(m_mul), .age(ent_age), .found(f_mul), .idx(i_mul));
    dq_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u_p_mem (
        .req(m_mem), .age(ent_age), .found(f_mem), .idx(i_mem));
    dq_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u_p_brf (
        .req(m_brf), .age(ent_age), .found(f_brf), .idx(i_brf));

    always_comb begin
        slot_vld    = {f_brf, f_mem, f_div | f_mul, f_alu1, f_alu0};
        slot_idx[0] = i_alu0;
        slot_idx[1] = i_alu1;
        slot_idx[2] = f_div ? i_div : i_mul;
        slot_idx[3] = i_mem;
        slot_idx[4] = i_brf;
        for (int s = 0; s < NSLOT; s++) begin
            slot_grant[s] = '0;
            if (slot_vld[s]) slot_grant[s][slot_idx[s]] = 1'b1;
        end
        ent_grant = '0;
        for (int s = 0; s < NSLOT; s++) begin
            ent_grant = ent_grant | slot_grant[s];
        end
    end
endmodule

// File: rtl/shared_slot_dispatch_chk.sv
module shared_slot_dispatch_chk
    import dq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [4:0]             slot_vld,
    input logic [4:0][IW-1:0]     slot_idx,
    input logic [4:0][DEPTH-1:0]  slot_grant,
    input logic [DEPTH-1:0]       ent_rdy,
    input logic [DEPTH-1:0]       ent_free,
    input logic [DEPTH-1:0][2:0]  ent_cls
);
    function automatic logic cls_ok(input int s, input logic [2:0] c);
        case (s)
            0, 1:    return c == CL_ALU;
            2:       return c == CL_MUL || c == CL_DIV;
            3:       return c == CL_LD || c == CL_ST;
            default: return c == CL_BR || c == CL_FPU;
        endcase
    endfunction

    logic [DEPTH-1:0] div_rdy;
    for (genvar e = 0; e < DEPTH; e++) begin : g_d
        assign div_rdy[e] = ent_rdy[e] && ent_cls[e] == CL_DIV;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> slot_vld == 5'b0);

    // R7
    alu_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        slot_vld[1] |-> (slot_vld[0] && slot_idx[1] != slot_idx[0]));

    // R6
    div_first_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld[2] && ent_cls[slot_idx[2]] == CL_MUL) |-> div_rdy == '0);

    // R6
    shared_one_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_grant[2]));

    for (genvar s = 0; s < 5; s++) begin : g_s
        // R3
        ready_only_chk: assert property (@(posedge clk) disable iff (rst)
            slot_vld[s] |-> ent_rdy[slot_idx[s]]);
        // R4
        class_map_chk: assert property (@(posedge clk) disable iff (rst)
            slot_vld[s] |-> cls_ok(s, ent_cls[slot_idx[s]]));
        // R8
        freed_next_chk: assert property (@(posedge clk) disable iff (rst)
            slot_vld[s] |=> ent_free[$past(slot_idx[s])]);
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_e
        // R8
        single_slot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0({slot_grant[4][e], slot_grant[3][e], slot_grant[2][e],
                      slot_grant[1][e], slot_grant[0][e]}));
    end
endmodule

bind shared_slot_dispatch shared_slot_dispatch_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_vld   (slot_vld),
    .slot_idx   (slot_idx),
    .slot_grant (slot_grant),
    .ent_rdy    (ent_rdy),
    .ent_free   (ent_free),
    .ent_cls    (ent_cls)
);

// File: tb/sim_shared_slot_dispatch.sv
`timescale 1ns/1ps
module sim_shared_slot_dispatch;
    localparam int DEPTH = 16;
    localparam int AGE_W = 8;
    localparam int IW    = 4;
    localparam int AMAX  = (1 << AGE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enq_valid = 1'b0;
    logic [IW-1:0] enq_idx = '0;
    logic [2:0] enq_class = '0, enq_ops = '0;
    logic set_valid = 1'b0;
    logic [IW-1:0] set_idx = '0;
    logic [2:0] set_mask = '0;
    logic [4:0] slot_vld;
    logic [4:0][IW-1:0] slot_idx;
    logic [4:0][DEPTH-1:0] slot_grant;

    always #4 clk = ~clk;

    shared_slot_dispatch #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)) u0 (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_idx(enq_idx), .enq_class(enq_class), .enq_ops(enq_ops),
        .set_valid(set_valid), .set_idx(set_idx), .set_mask(set_mask),
        .slot_vld(slot_vld), .slot_idx(slot_idx), .slot_grant(slot_grant));

    // model: 0 free, 1 wait, 2 ready
    int m_st[DEPTH], m_cls[DEPTH], m_ops[DEPTH], m_age[DEPTH];
    int errors = 0, checks = 0;
    bit done = 0;
    string dtag = "";
    string stag[5] = '{"R7", "R7", "R6", "R4", "R4"};

    function automatic int pick(input int ca, input int cb, input int excl);
        int best = -1;
        for (int i = 0; i < DEPTH; i++)
            if (m_st[i] == 2 && (m_cls[i] == ca || m_cls[i] == cb) && i != excl &&
                (best < 0 || m_age[i] > m_age[best])) best = i;
        return best;
    endfunction

    function automatic void expect_slots(output int e[5]);
        e[0] = pick(0, 0, -1);
        e[1] = (e[0] < 0) ? -1 : pick(0, 0, e[0]);
        e[2] = pick(2, 2, -1);
        if (e[2] < 0) e[2] = pick(1, 1, -1);
        e[3] = pick(3, 4, -1);
        e[4] = pick(5, 6, -1);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_st[i] = 0; m_cls[i] = 0; m_ops[i] = 0; m_age[i] = 0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; enq_valid = 1'b0; set_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (slot_vld !== 5'b0) begin
            errors++;
            $display("FAIL R1 during reset: slot_vld=%b expected 00000", slot_vld);
        end
        rst = 1'b0;
        model_clear();
    endtask

    // one cycle: check at negedge, drive, then advance the model at posedge
    task automatic step(input bit ev, input int ei, input int ec, input int eo,
                        input bit sv, input int si, input int sm);
        int e[5];
        int ost[DEPTH];
        @(negedge clk);
        expect_slots(e);
        for (int s = 0; s < 5; s++) begin
            bit ok;
            logic [DEPTH-1:0] eg;
            string t;
            eg = '0;
            if (e[s] >= 0) eg[e[s]] = 1'b1;
            ok = (e[s] < 0) ? (slot_vld[s] === 1'b0 && slot_grant[s] === '0)
                            : (slot_vld[s] === 1'b1 && int'(slot_idx[s]) == e[s] && slot_grant[s] === eg);
            t = (dtag != "") ? dtag : stag[s];
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s slot%0d: got vld=%b idx=%0d grant=%h expected idx=%0d grant=%h",
                         t, s, slot_vld[s], slot_idx[s], slot_grant[s], e[s], eg);
            end
        end
        enq_valid = ev; enq_idx = IW'(ei); enq_class = 3'(ec); enq_ops = 3'(eo);
        set_valid = sv; set_idx = IW'(si); set_mask = 3'(sm);
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) ost[i] = m_st[i];
        for (int i = 0; i < DEPTH; i++) begin
            bit g = 0;
            for (int s = 0; s < 5; s++) if (e[s] == i) g = 1;
            if (g) m_st[i] = 0;
            else if (ost[i] == 0) begin
                if (ev && ei == i) begin
                    m_cls[i] = ec; m_ops[i] = eo; m_age[i] = 0;
                    m_st[i] = (eo == 7) ? 2 : 1;
                end
            end else begin
                if (m_age[i] < AMAX) m_age[i]++;
                if (ost[i] == 1) begin
                    if (sv && si == i) m_ops[i] = m_ops[i] | sm;
                    if (m_ops[i] == 7) m_st[i] = 2;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_clear();
        do_reset();
        dtag = "R1"; step(0, 0, 0, 0, 0, 0, 0);

        // R2: overwrite attempt on occupied entry is ignored
        dtag = "R2";
        step(1, 2, 0, 0, 0, 0, 0);          // ALU, no operands -> WAIT
        step(1, 2, 3, 7, 0, 0, 0);          // LOAD onto idx 2: ignored
        step(0, 0, 0, 0, 1, 2, 7);          // complete operands
        idle(2);

        // R3: partial sets never make an entry eligible
        dtag = "R3";
        step(1, 5, 5, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 5, 2);
        step(0, 0, 0, 0, 1, 9, 7);          // set on a FREE entry: no effect
        step(0, 0, 0, 0, 1, 5, 4);
        idle(2);

        // R6: younger divide beats older multiply, multiply follows
        dtag = "R6";
        step(1, 3, 1, 3, 0, 0, 0);
        step(1, 8, 2, 7, 1, 3, 4);
        idle(3);

        // R5: older entry at higher index wins the memory slot
        dtag = "R5";
        step(1, 7, 3, 3, 0, 0, 0);
        step(1, 1, 4, 7, 1, 7, 4);
        idle(3);

        // R7: two ALU slots take the two oldest
        dtag = "R7";
        step(1, 4, 0, 3, 0, 0, 0);
        step(1, 6, 0, 3, 0, 0, 0);
        step(1, 0, 0, 7, 1, 4, 4);
        step(1, 10, 0, 7, 1, 6, 4);
        idle(3);

        // R8: granted entry is rewritten in the very next cycle
        dtag = "R8";
        step(1, 11, 6, 7, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 11, 5, 7, 0, 0, 0);
        idle(2);

        // R9: spare class stays put
        dtag = "R9";
        step(1, 9, 7, 7, 0, 0, 0);
        idle(4);

        dtag = "R1";
        do_reset();
        step(0, 0, 0, 0, 0, 0, 0);

        dtag = "";
        for (int n = 0; n < 3000; n++) begin
            bit ev, sv;
            int ec, eo;
            ev = ($urandom % 10) < 6;
            ec = $urandom % 7;
            eo = (($urandom % 2) == 0) ? 7 : int'($urandom % 8);
            sv = ($urandom % 2) == 1;
            step(ev, int'($urandom % DEPTH), ec, eo, sv, int'($urandom % DEPTH), int'($urandom % 8));
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule